// File: doc/BRIEF.md
# DDR SDRAM Start-Up Sequencer

This block sits on the controller side of a DDR SDRAM interface and brings the memory from power-on to the point where normal traffic may begin. It waits in a parked state until a supplies-good indication arrives. It then keeps the clock enable low for a programmable settling interval, counted in clock cycles from the clock frequency and the required time in microseconds. After that it issues a fixed series of commands on the command pins, with parameterized NOP gaps between them.

The series is: a single NOP with clock enable raised, a precharge of all banks, a write to the extended mode register that enables the DLL, and a base mode register write carrying the operating parameters with the DLL reset bit set. These are followed by a second all-bank precharge, two auto refreshes, and a final base mode register write with the DLL reset bit cleared. A completion flag rises once the last write has settled. A separate permission output gates read traffic. It stays low until a parameterized number of cycles has passed since the DLL-reset write. That count runs on its own, independently of the command sequence.

Top module: `ddr_init_seq`

## Requirements
- R1: While `rst` is high at a clock edge, the following cycle shows `clk_en`=0, command NOP, `init_complete`=0 and `rd_ok`=0.
- R2: Until `supplies_ok` is sampled high, the block keeps `clk_en` low and drives NOP.
- R3: After `supplies_ok` is accepted, `clk_en` stays low for exactly CLK_MHZ*PWRUP_US cycles. It then goes high and never falls again until reset. The first cycle with `clk_en` high carries a NOP.
- R4: Commands use {sel_n, row_strobe_n, col_strobe_n, wr_en_n} with NOP=0111, precharge=0010, auto refresh=0001 and mode register write=0000. Every precharge drives address bit 10 high (all banks). The order is NOP, precharge, extended write, DLL-reset write, precharge, refresh, refresh, final write.
- R5: The extended write uses bank select 01 and address EMR_OPS, whose bit 0 is 0 (DLL on). The DLL-reset write uses bank select 00 and address MR_OPS with bit DLL_RST_BIT set. The final write uses bank select 00 and address MR_OPS with that bit clear.
- R6: Issue times are spaced as follows: one cycle after the NOP, T_RP cycles after a precharge, T_MRD cycles after a mode register write, and T_RFC cycles after a refresh. Every cycle between commands is NOP.
- R7: `init_complete` rises exactly T_MRD cycles after the final write. It then stays high with NOP on the bus until reset.
- R8: `rd_ok` rises exactly DLL_LOCK_CYC cycles after the DLL-reset write and stays high until reset.
- R9: A synchronous reset in the middle of the sequence returns the block to the parked state with both flags cleared. A later start runs the full sequence again.
- R10: Once the settling interval has begun, changes on `supplies_ok` have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| supplies_ok | input | 1 | Supplies, reference and clock are stable |
| clk_en | output | 1 | Memory clock enable |
| sel_n | output | 1 | Chip select, active low |
| row_strobe_n | output | 1 | Row strobe, active low |
| col_strobe_n | output | 1 | Column strobe, active low |
| wr_en_n | output | 1 | Write enable, active low |
| bank_sel | output | BA_W | Bank select |
| mem_addr | output | ADDR_W | Address bus |
| init_complete | output | 1 | Start-up sequence finished |
| rd_ok | output | 1 | Read commands permitted |

## Verification
The completion flag and the read permission are produced by separate counters. With the bench's gap settings (T_MRD=2, T_RP=4, T_RFC=96), the time from the DLL-reset write to completion is exactly the default 200-cycle lock count, so both flags rise in the same cycle. The bench records the first cycle in which each flag is seen high. It then checks that both match the cycle computed from the timing parameters, and that neither rises one cycle early or late. Random start delays, random toggling of `supplies_ok` and random mid-sequence resets vary what leads up to that cycle.

// File: rtl/ddr_init_pkg.sv
package ddr_init_pkg;

   // {select, row strobe, column strobe, write enable}, all active low
   typedef enum logic [3:0] {
      CMD_MRS = 4'b0000,
      CMD_REF = 4'b0001,
      CMD_PRE = 4'b0010,
      CMD_NOP = 4'b0111
   } cmd_e;

   typedef enum logic [2:0] {
      ST_PARK,
      ST_SETTLE,
      ST_ISSUE,
      ST_GAP,
      ST_DONE
   } state_e;

   // order of this enum is the issue order
   typedef enum logic [2:0] {
      STP_NOP,
      STP_PRE_A,
      STP_EXT_WR,
      STP_DLL_RST,
      STP_PRE_B,
      STP_REF_A,
      STP_REF_B,
      STP_MODE_RUN
   } step_e;

endpackage

// File: rtl/ddr_init_timer.sv
module ddr_init_timer #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         load,
   input  logic [W-1:0] load_val,
   output logic         zero
);

   logic [W-1:0] cnt;

   always_ff @(posedge clk) begin
      if (rst)
         cnt <= '0;
      else if (load)
         cnt <= load_val;
      else if (cnt != '0)
         cnt <= cnt - 1'b1;
   end

   assign zero = (cnt == '0);

endmodule

// File: rtl/ddr_init_lockgate.sv
module ddr_init_lockgate #(
   parameter int LOCK_CYC = 200
) (
   input  logic clk,
   input  logic rst,
   input  logic start,
   output logic permit
);

   localparam int LW = $clog2(LOCK_CYC + 1);

   logic          armed;
   logic [LW-1:0] cnt;

   always_ff @(posedge clk) begin
      if (rst) begin
         armed <= 1'b0;
         cnt   <= '0;
      end else if (start) begin
         armed <= 1'b1;
         cnt   <= LW'(LOCK_CYC - 1);
      end else if (armed && cnt != '0) begin
         cnt   <= cnt - 1'b1;
      end
   end

   assign permit = armed && (cnt == '0);

   // R8: the start cycle is never followed directly by permission
   p_no_early_permit_r8: assert property (@(posedge clk) disable iff (rst)
      start |=> !permit);

   // R8: permission is sticky
   p_permit_sticky_r8: assert property (@(posedge clk) disable iff (rst)
      permit |=> permit);

endmodule

// File: rtl/ddr_init_seq.sv
module ddr_init_seq
   import ddr_init_pkg::*;
#(
   parameter int ADDR_W       = 13,
   parameter int BA_W         = 2,
   parameter int CLK_MHZ      = 100,
   parameter int PWRUP_US     = 200,
   parameter int T_RP         = 3,
   parameter int T_MRD        = 2,
   parameter int T_RFC        = 10,
   parameter int DLL_LOCK_CYC = 200,
   parameter int DLL_RST_BIT  = 8,
   parameter logic [ADDR_W-1:0] MR_OPS  = 'h032,
   parameter logic [ADDR_W-1:0] EMR_OPS = 'h000
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              supplies_ok,
   output logic              clk_en,
   output logic              sel_n,
   output logic              row_strobe_n,
   output logic              col_strobe_n,
   output logic              wr_en_n,
   output logic [BA_W-1:0]   bank_sel,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              init_complete,
   output logic              rd_ok
);

   localparam int PWRUP_CYC = CLK_MHZ * PWRUP_US;
   localparam int TW        = $clog2(PWRUP_CYC + T_RP + T_MRD + T_RFC + 1);
   localparam logic [ADDR_W-1:0] DLL_MASK = ADDR_W'(1) << DLL_RST_BIT;
   localparam logic [ADDR_W-1:0] ALLB_MASK = ADDR_W'(1) << 10;

   // elaboration-time parameter checks
   if (ADDR_W < 11) begin : g_bad_addr
      $error("ADDR_W must reach the all-bank address bit");
   end
   if (BA_W < 2) begin : g_bad_ba
      $error("BA_W must be at least 2");
   end
   if (PWRUP_CYC < 1) begin : g_bad_pwr
      $error("settling interval must be at least one cycle");
   end
   if (T_RP < 2 || T_MRD < 2 || T_RFC < 2) begin : g_bad_gap
      $error("command spacings must be at least 2 cycles");
   end
   if (DLL_LOCK_CYC < 2) begin : g_bad_lock
      $error("DLL_LOCK_CYC must be at least 2");
   end
   if (DLL_RST_BIT >= ADDR_W || DLL_RST_BIT == 10) begin : g_bad_dllbit
      $error("DLL_RST_BIT out of range");
   end
   if (MR_OPS[DLL_RST_BIT] || EMR_OPS[0]) begin : g_bad_ops
      $error("MR_OPS must clear the DLL reset bit, EMR_OPS must enable the DLL");
   end

   state_e          state, state_n;
   step_e           step, step_n;
   logic            tmr_load, tmr_zero;
   logic [TW-1:0]   tmr_val;
   logic [TW-1:0]   gap_now;
   cmd_e            cmd;

   function automatic logic [TW-1:0] gap_of(step_e s);
      case (s)
         STP_NOP:                         gap_of = TW'(1);
         STP_PRE_A, STP_PRE_B:            gap_of = TW'(T_RP);
         STP_REF_A, STP_REF_B:            gap_of = TW'(T_RFC);
         default:                         gap_of = TW'(T_MRD);
      endcase
   endfunction

   function automatic cmd_e cmd_of(step_e s);
      case (s)
         STP_NOP:                         cmd_of = CMD_NOP;
         STP_PRE_A, STP_PRE_B:            cmd_of = CMD_PRE;
         STP_REF_A, STP_REF_B:            cmd_of = CMD_REF;
         default:                         cmd_of = CMD_MRS;
      endcase
   endfunction

   assign gap_now = gap_of(step);

   always_comb begin
      state_n  = state;
      step_n   = step;
      tmr_load = 1'b0;
      tmr_val  = '0;
      case (state)
         ST_PARK: begin
            if (supplies_ok) begin
               state_n  = ST_SETTLE;
               tmr_load = 1'b1;
               tmr_val  = TW'(PWRUP_CYC - 1);
            end
         end
         ST_SETTLE: begin
            if (tmr_zero) begin
               state_n = ST_ISSUE;
               step_n  = STP_NOP;
            end
         end
         ST_ISSUE: begin
            if (gap_now == TW'(1)) begin
               step_n = step_e'(step + 3'd1);
            end else begin
               state_n  = ST_GAP;
               tmr_load = 1'b1;
               tmr_val  = gap_now - TW'(2);
            end
         end
         ST_GAP: begin
            if (tmr_zero) begin
               if (step == STP_MODE_RUN) begin
                  state_n = ST_DONE;
               end else begin
                  state_n = ST_ISSUE;
                  step_n  = step_e'(step + 3'd1);
               end
            end
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         state <= ST_PARK;
         step  <= STP_NOP;
      end else begin
         state <= state_n;
         step  <= step_n;
      end
   end

   ddr_init_timer #(.W(TW)) u_timer (
      .clk      (clk),
      .rst      (rst),
      .load     (tmr_load),
      .load_val (tmr_val),
      .zero     (tmr_zero)
   );

   ddr_init_lockgate #(.LOCK_CYC(DLL_LOCK_CYC)) u_lockgate (
      .clk    (clk),
      .rst    (rst),
      .start  (state == ST_ISSUE && step == STP_DLL_RST),
      .permit (rd_ok)
   );

   // command and address drive
   always_comb begin
      cmd      = (state == ST_ISSUE) ? cmd_of(step) : CMD_NOP;
      bank_sel = '0;
      mem_addr = '0;
      if (state == ST_ISSUE) begin
         case (step)
            STP_PRE_A, STP_PRE_B: mem_addr = ALLB_MASK;
            STP_EXT_WR: begin
               bank_sel = BA_W'(1);
               mem_addr = EMR_OPS;
            end
            STP_DLL_RST:          mem_addr = MR_OPS | DLL_MASK;
            STP_MODE_RUN:         mem_addr = MR_OPS;
            default: ;
         endcase
      end
   end

   assign {sel_n, row_strobe_n, col_strobe_n, wr_en_n} = cmd;
   assign clk_en        = (state == ST_ISSUE) || (state == ST_GAP) || (state == ST_DONE);
   assign init_complete = (state == ST_DONE);

   // R3: clock enable never drops without reset
   p_cke_sticky_r3: assert property (@(posedge clk) disable iff (rst)
      clk_en |=> clk_en);

   // R4: an executable command is only driven with clock enable high
   p_cmd_needs_cke_r4: assert property (@(posedge clk) disable iff (rst)
      (cmd != CMD_NOP) |-> clk_en);

   // R6: every real command is followed by at least one NOP cycle
   p_gap_nop_r6: assert property (@(posedge clk) disable iff (rst)
      (cmd != CMD_NOP) |=> (cmd == CMD_NOP));

   // R7: completion is sticky and the bus rests at NOP
   p_done_sticky_r7: assert property (@(posedge clk) disable iff (rst)
      init_complete |=> init_complete);

   p_done_quiet_r7: assert property (@(posedge clk) disable iff (rst)
      init_complete |-> (cmd == CMD_NOP));

endmodule

// File: tb/ddr_init_seq_tb.sv
module ddr_init_seq_tb;

   localparam int ADDR_W = 13;
   localparam int BA_W   = 2;
   localparam int CLK_MHZ = 100;
   localparam int PWRUP_US = 5;
   localparam int T_RP  = 4;
   localparam int T_MRD = 2;
   localparam int T_RFC = 96;
   localparam int LOCK  = 200;
   localparam int DLLB  = 8;
   localparam logic [ADDR_W-1:0] MRV  = 13'h0032;
   localparam logic [ADDR_W-1:0] EMRV = 13'h0000;
   localparam int PW = CLK_MHZ * PWRUP_US;

   // issue offsets counted from the first cycle with clock enable high
   localparam int O_PRE_A = 1;
   localparam int O_EXT   = O_PRE_A + T_RP;
   localparam int O_DLL   = O_EXT + T_MRD;
   localparam int O_PRE_B = O_DLL + T_MRD;
   localparam int O_REF_A = O_PRE_B + T_RP;
   localparam int O_REF_B = O_REF_A + T_RFC;
   localparam int O_RUN   = O_REF_B + T_RFC;
   localparam int O_DONE  = O_RUN + T_MRD;
   localparam int O_RD    = O_DLL + LOCK;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic supplies_ok = 1'b0;
   logic clk_en, sel_n, row_strobe_n, col_strobe_n, wr_en_n;
   logic [BA_W-1:0] bank_sel;
   logic [ADDR_W-1:0] mem_addr;
   logic init_complete, rd_ok;

   int nchk = 0;
   int nfail = 0;
   int t = 0;
   int first_done = -1;
   int first_rd = -1;

   always #5 clk = ~clk;

   ddr_init_seq #(
      .ADDR_W(ADDR_W), .BA_W(BA_W), .CLK_MHZ(CLK_MHZ), .PWRUP_US(PWRUP_US),
      .T_RP(T_RP), .T_MRD(T_MRD), .T_RFC(T_RFC), .DLL_LOCK_CYC(LOCK),
      .DLL_RST_BIT(DLLB), .MR_OPS(MRV), .EMR_OPS(EMRV)
   ) u_dut (
      .clk(clk), .rst(rst), .supplies_ok(supplies_ok), .clk_en(clk_en),
      .sel_n(sel_n), .row_strobe_n(row_strobe_n), .col_strobe_n(col_strobe_n),
      .wr_en_n(wr_en_n), .bank_sel(bank_sel), .mem_addr(mem_addr),
      .init_complete(init_complete), .rd_ok(rd_ok)
   );

   function automatic int exp_cmd(int o);
      if (o == O_PRE_A || o == O_PRE_B) return 4'b0010;
      if (o == O_REF_A || o == O_REF_B) return 4'b0001;
      if (o == O_EXT || o == O_DLL || o == O_RUN) return 4'b0000;
      return 4'b0111;
   endfunction

   function automatic int exp_ba(int o);
      return (o == O_EXT) ? 1 : 0;
   endfunction

   function automatic int exp_addr(int o);
      if (o == O_EXT) return int'(EMRV);
      if (o == O_DLL) return int'(MRV) | (1 << DLLB);
      return int'(MRV);
   endfunction

   task automatic chk(string tag, string what, int act, int exp);
      nchk++;
      if (act != exp) begin
         nfail++;
         $display("FAIL %s %s act=%0d exp=%0d (t=%0d)", tag, what, act, exp, t);
      end
   endtask

   task automatic check_all(string ctx);
      int o = t - (PW + 1);
      bit on = (t > PW);
      int ec = on ? exp_cmd(o) : 4'b0111;
      int ac = {28'd0, sel_n, row_strobe_n, col_strobe_n, wr_en_n};
      string tc;
      tc = (ctx != "") ? ctx : ((on && ec == 4'b0111 && o > 0) ? "R6" : "R4");
      chk((ctx != "") ? ctx : ((t == 0) ? "R2" : "R3"), "clk_en", int'(clk_en), int'(on));
      chk(tc, "cmd", ac, ec);
      if (on && ec == 4'b0000) begin
         chk("R5", "bank_sel", int'(bank_sel), exp_ba(o));
         chk("R5", "mem_addr", int'(mem_addr), exp_addr(o));
      end
      if (on && ec == 4'b0010)
         chk("R4", "addr_bit10", int'(mem_addr[10]), 1);
      chk((ctx != "") ? ctx : "R7", "init_complete", int'(init_complete), int'(on && o >= O_DONE));
      chk((ctx != "") ? ctx : "R8", "rd_ok", int'(rd_ok), int'(on && o >= O_RD));
      if (init_complete && first_done < 0) first_done = o;
      if (rd_ok && first_rd < 0) first_rd = o;
   endtask

   task automatic step(logic r, logic s, string ctx);
      rst = r;
      supplies_ok = s;
      @(posedge clk);
      if (r) t = 0;
      else if (t == 0) t = s ? 1 : 0;
      else t++;
      @(negedge clk);
      check_all(ctx);
   endtask

   task automatic run_to_end(bit toggle);
      while (t < PW + 1 + O_DONE + 6)
         step(1'b0, toggle ? 1'($urandom_range(0, 1)) : 1'b1, toggle ? "R10" : "");
   endtask

   initial begin
      int seed_dummy;
      seed_dummy = $urandom(32'd1234);
      @(negedge clk);
      // R1: reset state
      step(1'b1, 1'b1, "R1");
      step(1'b1, 1'b0, "R1");

      // run A: random park time, then a clean sequence
      for (int i = 0; i < int'($urandom_range(3, 15)); i++) step(1'b0, 1'b0, "R2");
      first_done = -1; first_rd = -1;
      step(1'b0, 1'b1, "");
      run_to_end(1'b0);
      // R7 and R8 rise in the same cycle for these timings
      chk("R7", "first_done_offset", first_done, O_DONE);
      chk("R8", "first_rd_offset", first_rd, O_RD);
      chk("R8", "done_rd_same_cycle", int'(first_done == first_rd), 1);

      // run B: supplies_ok toggles randomly after start (R10)
      step(1'b1, 1'b0, "R1");
      step(1'b0, 1'b1, "");
      run_to_end(1'b1);

      // run C: reset at a random point, then a full rerun (R9)
      for (int k = 0; k < 3; k++) begin
         int stop_at;
         step(1'b1, 1'b0, "R1");
         step(1'b0, 1'b1, "");
         stop_at = (k == 0) ? PW : int'($urandom_range(2, PW + O_DONE + 3));
         while (t < stop_at) step(1'b0, 1'b1, "");
         step(1'b1, 1'b1, "R9");
         for (int i = 0; i < 4; i++) step(1'b0, 1'b0, "R9");
      end
      first_done = -1; first_rd = -1;
      step(1'b0, 1'b1, "");
      run_to_end(1'b0);
      chk("R9", "rerun_done_offset", first_done, O_DONE);

      $display("  [TB] %0d tests run, %0d failed", nchk, nfail);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      nfail++;
      $display("FAIL R7 watchdog act=running exp=finished");
      $display("  [TB] %0d tests run, %0d failed", nchk, nfail);
      $finish;
   end

endmodule